// File: doc/BRIEF.md
# Port Controller with Mailbox Bypass

This block is the control logic for one side of a pair of FIFOs that carry data between two clock domains. On each rising edge of the local clock it turns four select inputs (chip select, direction, enable and mailbox select) into one of four operations. These are a write into the outbound FIFO, a read from the inbound FIFO, a write into the outbound mail register, or a read of the inbound mail register. The FIFOs sit outside the block. The block drives their write and read strobes and takes their space and data-available flags back as inputs.

The mailbox is a one-word path that bypasses the FIFOs and uses the same port pins. Each mail register has a flag that is high when the register is free and low when a word is waiting for the other side. A write on one side pulls the flag low. The read on the far side returns it high. Each side sees the flag through a two-flop synchronizer into its own clock.

The block also chooses what the 36-bit data output shows: the inbound FIFO output word, or the inbound mail word. It also decides when that output is released to high impedance.

Top module: `portMailCtrl`

## Requirements
- R1: `portDrive` is 1, and `portData` is driven, only when `csN` is 0 and `dirWr` is 0. In every other case `portDrive` is 0 and `portData` is high impedance.
- R2: `outWrEn` is 1 exactly when `csN`=0, `dirWr`=1, `en`=1, `mbSel`=0 and `outSpace`=1. `outWrData` equals `portIn`.
- R3: `inRdEn` is 1 exactly when `csN`=0, `dirWr`=0, `en`=1, `mbSel`=0 and `inAvail`=1.
- R4: While driven, `portData` shows `inRdData` when `mbSel`=0 and the inbound mail word when `mbSel`=1.
- R5: With `en`=0, no FIFO strobe is raised and neither mail register nor mail flag changes, whatever the other selects are.
- R6: Reset (`rstN`=0) sets all four mail flags high (`outMailFlag`, `inMailFlag`, `remOutFlag`, `remInFlag`) and clears both mail words to zero.
- R7: A local mail write (`csN`=0, `dirWr`=1, `en`=1, `mbSel`=1) while `outMailFlag` is 1 stores `portIn` and drives `outMailFlag` low after that edge. Within three `remClk` edges, `remOutFlag` is low and `remOutMail` carries the word.
- R8: A local mail write while `outMailFlag` is 0 is ignored. `remOutMail` keeps the earlier word.
- R9: A local mail read (`csN`=0, `dirWr`=0, `en`=1, `mbSel`=1) while `inMailFlag` is 0 sets `inMailFlag` high after that edge. Within three `remClk` edges, `remInFlag` returns high.
- R10: A local mail read while `inMailFlag` is 1 is ignored. Both `inMailFlag` and `remInFlag` stay high.
- R11: A remote read (`remMailRd`=1 at a `remClk` edge) of a pending outbound word sets `remOutFlag` high at once and `outMailFlag` high within three `clk` edges.
- R12: A remote write (`remMailWr`=1 at a `remClk` edge) while `remInFlag` is 1 stores `remMailIn` and pulls `remInFlag` low. Within three `clk` edges, `inMailFlag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local port clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Port select, active low |
| dirWr | input | 1 | 1 selects write into the block, 0 selects read out of it |
| en | input | 1 | Operation enable for the current edge |
| mbSel | input | 1 | 1 routes the operation to the mail registers |
| portIn | input | 36 | Write data from the port |
| portData | output | 36 | Read data to the port, high impedance when not driven |
| portDrive | output | 1 | 1 while portData is driven |
| outSpace | input | 1 | Outbound FIFO can accept a word |
| outWrEn | output | 1 | Outbound FIFO write strobe |
| outWrData | output | 36 | Outbound FIFO write data |
| inAvail | input | 1 | Inbound FIFO holds a word |
| inRdData | input | 36 | Inbound FIFO output register |
| inRdEn | output | 1 | Inbound FIFO read strobe |
| outMailFlag | output | 1 | Outbound mail free (1) or pending (0), local clock |
| inMailFlag | output | 1 | Inbound mail absent (1) or waiting (0), local clock |
| remClk | input | 1 | Clock of the far port |
| remMailWr | input | 1 | Far-side write of the inbound mail register |
| remMailIn | input | 36 | Far-side mail write data |
| remMailRd | input | 1 | Far-side read of the outbound mail register |
| remOutMail | output | 36 | Outbound mail word as seen by the far side |
| remOutFlag | output | 1 | Outbound mail absent (1) or waiting (0), far clock |
| remInFlag | output | 1 | Inbound mail free (1) or pending (0), far clock |

## Verification
A decode fault, such as a missing enable term or a wrong full or empty gate, shows on the FIFO strobes or on `portDrive` in the same cycle as the bad input pattern. The random select stream finds these faults within a few cycles. A mail toggle that is lost or doubled leaves a flag at the wrong level. The locally written side shows this one edge after the operation, and the far side shows it after its synchronizer, within three edges. An accepted overwrite of a pending word appears as a changed `remOutMail` value on the next far-side check.

// File: rtl/portmail_pkg.sv
package portmail_pkg;

  typedef struct packed {
    logic fifoWr;
    logic fifoRd;
    logic mailWr;
    logic mailRd;
    logic drive;
    logic showMail;
  } portStrobes_t;

endpackage

// File: rtl/bitSync.sv
module bitSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mailSlot.sv
module mailSlot #(
  parameter int W           = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic         wClk,
  input  logic         rClk,
  input  logic         rstN,
  input  logic         wrReq,
  input  logic [W-1:0] wrData,
  input  logic         rdReq,
  output logic [W-1:0] mailData,
  output logic         wrFlag,
  output logic         rdFlag
);
  logic wrTog, rdTog, rdTogAtW, wrTogAtR;
  logic [W-1:0] dataQ;

  // writer side: flag high means the slot is free
  assign wrFlag = (wrTog == rdTogAtW);
  // reader side: flag high means no word is waiting
  assign rdFlag = (wrTogAtR == rdTog);

  always_ff @(posedge wClk or negedge rstN) begin
    if (!rstN) begin
      wrTog <= 1'b0;
      dataQ <= '0;
    end else if (wrReq && wrFlag) begin
      wrTog <= ~wrTog;
      dataQ <= wrData;
    end
  end

  always_ff @(posedge rClk or negedge rstN) begin
    if (!rstN)                rdTog <= 1'b0;
    else if (rdReq && !rdFlag) rdTog <= ~rdTog;
  end

  bitSync #(.STAGES(SYNC_STAGES)) toReader_i (
    .clk(rClk), .rstN(rstN), .d(wrTog), .q(wrTogAtR)
  );
  bitSync #(.STAGES(SYNC_STAGES)) toWriter_i (
    .clk(wClk), .rstN(rstN), .d(rdTog), .q(rdTogAtW)
  );

  assign mailData = dataQ;
endmodule

// File: rtl/portDecode.sv
module portDecode
  import portmail_pkg::*;
(
  input  logic         csN,
  input  logic         dirWr,
  input  logic         en,
  input  logic         mbSel,
  input  logic         outSpace,
  input  logic         inAvail,
  output portStrobes_t strb
);
  logic selWr, selRd;

  always_comb begin
    selWr         = !csN && dirWr && en;
    selRd         = !csN && !dirWr && en;
    strb.drive    = !csN && !dirWr;
    strb.showMail = mbSel;
    strb.fifoWr   = selWr && !mbSel && outSpace;
    strb.fifoRd   = selRd && !mbSel && inAvail;
    strb.mailWr   = selWr && mbSel;
    strb.mailRd   = selRd && mbSel;
  end
endmodule

// File: rtl/portDatapath.sv
module portDatapath
  import portmail_pkg::*;
#(
  parameter int W = 36
) (
  input  portStrobes_t strb,
  input  logic [W-1:0] portIn,
  input  logic [W-1:0] inRdData,
  input  logic [W-1:0] inMailData,
  output logic [W-1:0] outWrData,
  output logic [W-1:0] driveVal,
  output logic         driveEn
);
  assign outWrData = portIn;
  assign driveVal  = strb.showMail ? inMailData : inRdData;
  assign driveEn   = strb.drive;
endmodule

// File: rtl/portMailCtrl.sv
module portMailCtrl
  import portmail_pkg::*;
#(
  parameter int W           = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         dirWr,
  input  logic         en,
  input  logic         mbSel,
  input  logic [W-1:0] portIn,
  output logic [W-1:0] portData,
  output logic         portDrive,
  input  logic         outSpace,
  output logic         outWrEn,
  output logic [W-1:0] outWrData,
  input  logic         inAvail,
  input  logic [W-1:0] inRdData,
  output logic         inRdEn,
  output logic         outMailFlag,
  output logic         inMailFlag,
  input  logic         remClk,
  input  logic         remMailWr,
  input  logic [W-1:0] remMailIn,
  input  logic         remMailRd,
  output logic [W-1:0] remOutMail,
  output logic         remOutFlag,
  output logic         remInFlag
);
  portStrobes_t strb;
  logic [W-1:0] inMailData, driveVal;
  logic         driveEn;

  portDecode decode_i (
    .csN(csN), .dirWr(dirWr), .en(en), .mbSel(mbSel),
    .outSpace(outSpace), .inAvail(inAvail), .strb(strb)
  );

  portDatapath #(.W(W)) data_i (
    .strb(strb), .portIn(portIn), .inRdData(inRdData),
    .inMailData(inMailData), .outWrData(outWrData),
    .driveVal(driveVal), .driveEn(driveEn)
  );

  // outbound: written locally, read by the far port
  mailSlot #(.W(W), .SYNC_STAGES(SYNC_STAGES)) outMail_i (
    .wClk(clk), .rClk(remClk), .rstN(rstN),
    .wrReq(strb.mailWr), .wrData(portIn), .rdReq(remMailRd),
    .mailData(remOutMail), .wrFlag(outMailFlag), .rdFlag(remOutFlag)
  );

  // inbound: written by the far port, read locally
  mailSlot #(.W(W), .SYNC_STAGES(SYNC_STAGES)) inMail_i (
    .wClk(remClk), .rClk(clk), .rstN(rstN),
    .wrReq(remMailWr), .wrData(remMailIn), .rdReq(strb.mailRd),
    .mailData(inMailData), .wrFlag(remInFlag), .rdFlag(inMailFlag)
  );

  assign outWrEn   = strb.fifoWr;
  assign inRdEn    = strb.fifoRd;
  assign portDrive = driveEn;
  assign portData  = driveEn ? driveVal : {W{1'bz}};
endmodule

// File: rtl/portMailCtrl_chk.sv
module portMailCtrl_chk #(
  parameter int W = 36
) (
  input logic         clk,
  input logic         rstN,
  input logic         csN,
  input logic         dirWr,
  input logic         en,
  input logic         mbSel,
  input logic         portDrive,
  input logic         outSpace,
  input logic         outWrEn,
  input logic         inAvail,
  input logic         inRdEn,
  input logic         outMailFlag,
  input logic         inMailFlag,
  input logic [W-1:0] remOutMail
);
  // R1: released whenever not selected for a read
  a_r1_release: assert property (@(posedge clk) disable iff (!rstN)
    (csN || dirWr) |-> !portDrive);

  // R2: outbound FIFO write only with space and the FIFO path chosen
  a_r2_wr_guard: assert property (@(posedge clk) disable iff (!rstN)
    outWrEn |-> (outSpace && en && !mbSel && !csN));

  // R3: inbound FIFO read only with data present on a driven port
  a_r3_rd_guard: assert property (@(posedge clk) disable iff (!rstN)
    inRdEn |-> (inAvail && portDrive && en && !mbSel));

  // R5: no FIFO strobe without enable
  a_r5_idle: assert property (@(posedge clk) disable iff (!rstN)
    !en |-> (!outWrEn && !inRdEn));

  // R7: accepted mail write marks the slot pending
  a_r7_post: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && dirWr && en && mbSel && outMailFlag) |=> !outMailFlag);

  // R8: pending outbound word is never overwritten
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outMailFlag |=> $stable(remOutMail));

  // R9: accepted mail read clears the waiting mark
  a_r9_take: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !dirWr && en && mbSel && !inMailFlag) |=> inMailFlag);
endmodule

bind portMailCtrl portMailCtrl_chk #(.W(W)) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .dirWr(dirWr), .en(en),
  .mbSel(mbSel), .portDrive(portDrive), .outSpace(outSpace),
  .outWrEn(outWrEn), .inAvail(inAvail), .inRdEn(inRdEn),
  .outMailFlag(outMailFlag), .inMailFlag(inMailFlag),
  .remOutMail(remOutMail)
);

// File: tb/portMailCtrl_tb_top.sv
`timescale 1ns/1ps
module portMailCtrl_tb_top;
  localparam int W = 36;

  logic clk = 0, remClk = 0, rstN = 0;
  logic csN = 1, dirWr = 0, en = 0, mbSel = 0, outSpace = 0, inAvail = 0;
  logic remMailWr = 0, remMailRd = 0;
  logic [W-1:0] portIn = '0, inRdData = '0, remMailIn = '0;
  wire  [W-1:0] portData, outWrData, remOutMail;
  wire  portDrive, outWrEn, inRdEn, outMailFlag, inMailFlag, remOutFlag, remInFlag;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;        // 125 MHz
  always #5.5 remClk = ~remClk;

  portMailCtrl #(.W(W)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .dirWr(dirWr), .en(en), .mbSel(mbSel),
    .portIn(portIn), .portData(portData), .portDrive(portDrive),
    .outSpace(outSpace), .outWrEn(outWrEn), .outWrData(outWrData),
    .inAvail(inAvail), .inRdData(inRdData), .inRdEn(inRdEn),
    .outMailFlag(outMailFlag), .inMailFlag(inMailFlag),
    .remClk(remClk), .remMailWr(remMailWr), .remMailIn(remMailIn),
    .remMailRd(remMailRd), .remOutMail(remOutMail),
    .remOutFlag(remOutFlag), .remInFlag(remInFlag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expWr(logic c, logic d, logic e, logic m, logic s);
    return !c && d && e && !m && s;
  endfunction
  function automatic logic expRd(logic c, logic d, logic e, logic m, logic a);
    return !c && !d && e && !m && a;
  endfunction

  task automatic doReset();
    rstN = 0; csN = 1; en = 0; remMailWr = 0; remMailRd = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic localOp(input logic d, input logic m, input logic [W-1:0] v);
    @(negedge clk);
    csN = 0; dirWr = d; mbSel = m; en = 1; portIn = v;
    @(negedge clk);
    en = 0;
  endtask

  task automatic remPulse(input bit wr, input logic [W-1:0] v);
    @(negedge remClk);
    if (wr) begin remMailWr = 1; remMailIn = v; end
    else remMailRd = 1;
    @(negedge remClk);
    remMailWr = 0; remMailRd = 0;
    #1;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic expOutFlag;
    logic [W-1:0] expData;
    void'($urandom(32'h5eed_1234));
    doReset();
    // R6 reset state
    chk("R6 outMailFlag", outMailFlag, 1);
    chk("R6 inMailFlag", inMailFlag, 1);
    chk("R6 remOutFlag", remOutFlag, 1);
    chk("R6 remInFlag", remInFlag, 1);
    chk("R6 remOutMail", remOutMail, 0);

    // random decode phase, far port idle
    expOutFlag = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      csN = $urandom_range(0, 3) == 0;
      dirWr = $urandom_range(0, 1); en = $urandom_range(0, 2) != 0;
      mbSel = $urandom_range(0, 3) == 0;
      outSpace = $urandom_range(0, 1); inAvail = $urandom_range(0, 1);
      portIn = {$urandom, $urandom};
      inRdData = {$urandom, $urandom};
      #1;
      chk("R1 drive", portDrive, !csN && !dirWr);
      chk("R2 outWrEn", outWrEn, expWr(csN, dirWr, en, mbSel, outSpace));
      chk("R2 outWrData", outWrData, portIn);
      chk("R3 inRdEn", inRdEn, expRd(csN, dirWr, en, mbSel, inAvail));
      chk("R5 outMailFlag", outMailFlag, expOutFlag);
      chk("R10 inMailFlag", inMailFlag, 1);
      if (portDrive) begin
        expData = mbSel ? '0 : inRdData;
        chk("R4 portData", portData, expData);
      end
      if (!csN && dirWr && en && mbSel) expOutFlag = 0;
    end

    // directed mailbox sequence
    doReset();
    localOp(1, 1, 36'h0A5A5_0001);
    #1 chk("R7 local flag low", outMailFlag, 0);
    repeat (4) @(negedge remClk);
    chk("R7 remote flag low", remOutFlag, 0);
    chk("R7 remote data", remOutMail, 36'h0A5A5_0001);
    localOp(1, 1, 36'h0BEEF_0002);
    repeat (4) @(negedge remClk);
    chk("R8 data kept", remOutMail, 36'h0A5A5_0001);
    chk("R8 flag kept", outMailFlag, 0);
    remPulse(0, '0);
    chk("R11 remote flag high", remOutFlag, 1);
    repeat (4) @(negedge clk);
    chk("R11 local flag high", outMailFlag, 1);
    localOp(1, 1, 36'h0C0DE_0003);
    repeat (4) @(negedge remClk);
    chk("R7 second word", remOutMail, 36'h0C0DE_0003);

    remPulse(1, 36'h9_1234_5678);
    chk("R12 remote flag low", remInFlag, 0);
    repeat (4) @(negedge clk);
    chk("R12 local flag low", inMailFlag, 0);
    csN = 0; dirWr = 0; mbSel = 1; en = 0; #1;
    chk("R4 mail shown", portData, 36'h9_1234_5678);
    chk("R1 driven on read select", portDrive, 1);
    localOp(0, 1, '0);
    #1 chk("R9 local flag high", inMailFlag, 1);
    repeat (4) @(negedge remClk);
    chk("R9 remote flag high", remInFlag, 1);
    localOp(0, 1, '0);
    repeat (4) @(negedge remClk);
    chk("R10 local flag", inMailFlag, 1);
    chk("R10 remote flag", remInFlag, 1);
    // enable low: mail write ignored
    @(negedge clk); csN = 0; dirWr = 1; mbSel = 1; en = 0; portIn = 36'h7;
    @(negedge clk); #1;
    chk("R5 no mail write", outMailFlag, 0);
    csN = 1;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule